// File: doc/BRIEF.md
# Wide Bitwise Logic and Funnel-Shift Unit

This block is the combinational logic datapath of a wide-word big-number processor. It takes two `WLEN`-bit operands and an operation code and produces one `WLEN`-bit result in the same cycle. The supported operations are AND, OR, XOR, NOT, a funnel right shift and a flag-driven select.

For AND, OR, XOR and NOT, the second operand first passes through a byte shifter. That shifter moves the operand left or right by a whole number of bytes and fills the vacated bytes with zeros. The funnel shift joins the two operands into one double-width value, with the first operand on top. It shifts that value right by an immediate bit count and keeps the low word. The select operation returns one of the two operands, chosen by one bit of a four-bit flag group.

The register file, the flag storage and instruction decoding are outside the block. Nothing is registered and no flags are produced.

Top module: `wide_logic_unit`

## Requirements
- R1: With `op_i` = 0 (AND), 1 (OR) or 2 (XOR), `result_o` equals `opa_i` combined bitwise with the byte-shifted second operand.
- R2: When `shift_right_i` is 0, the second operand is shifted toward the most significant end by 8·`shift_bytes_i` bits, and the vacated low bytes become zero.
- R3: When `shift_right_i` is 1, the second operand is shifted toward the least significant end by 8·`shift_bytes_i` bits, and the vacated high bytes become zero.
- R4: With `op_i` = 3 (NOT), `result_o` is the bitwise inverse of the byte-shifted `opb_i`, and `opa_i` has no effect on it.
- R5: With `op_i` = 4 (funnel), `result_o` is the low `WLEN` bits of {`opa_i`,`opb_i`} shifted right by `funnel_amt_i` bits. The byte-shift inputs have no effect in this mode.
- R6: With `op_i` = 5 (select), `result_o` is `opa_i` when `flags_i[flag_sel_i]` is 1 and the unshifted `opb_i` otherwise. The flag bits are carry at bit 0, MSB at bit 1, LSB at bit 2 and zero at bit 3.
- R7: With `op_i` = 6 or 7, `result_o` is all zeros.
- R8: A byte count of 0 passes the second operand through unchanged. A count of 8·count ≥ `WLEN` clears it to zero, and a count of 31 at `WLEN` = 256 keeps exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | WLEN | First source operand |
| opb_i | input | WLEN | Second source operand (byte-shifted for logic operations) |
| op_i | input | 3 | Operation code: 0 AND, 1 OR, 2 XOR, 3 NOT, 4 funnel, 5 select |
| shift_right_i | input | 1 | Byte-shift direction: 0 toward MSB, 1 toward LSB |
| shift_bytes_i | input | SHB_W | Byte-shift count |
| funnel_amt_i | input | clog2(WLEN) | Funnel right-shift bit count |
| flags_i | input | 4 | Flag group: carry, MSB, LSB, zero in bits 0 to 3 |
| flag_sel_i | input | 2 | Index of the flag that drives the select |
| result_o | output | WLEN | Operation result |

## Verification
The bench builds two copies of the unit. One uses the default `WLEN` = 256, where the largest byte count of 31 still keeps one byte and the funnel immediate spans 8 bits. The other uses `WLEN` = 64, where every byte count of 8 or more pushes the whole operand out of range, so the zeroing stages of the shifter are exercised. That copy's 6-bit funnel immediate also reaches the far end of a narrower double-width value. Both copies receive the same stimulus and are compared against a byte-by-byte and bit-by-bit model.

// File: rtl/wlu_pkg.sv
package wlu_pkg;

  typedef enum logic [2:0] {
    OP_AND    = 3'd0,
    OP_OR     = 3'd1,
    OP_XOR    = 3'd2,
    OP_NOT    = 3'd3,
    OP_FUNNEL = 3'd4,
    OP_SELECT = 3'd5,
    OP_RSVD6  = 3'd6,
    OP_RSVD7  = 3'd7
  } wlu_op_e;

  localparam int unsigned FLAG_N     = 4;
  localparam int unsigned FLAG_CARRY = 0;
  localparam int unsigned FLAG_MSB   = 1;
  localparam int unsigned FLAG_LSB   = 2;
  localparam int unsigned FLAG_ZERO  = 3;

  // Pick one flag of the group by its two-bit index.
  function automatic logic pick_flag(input logic [FLAG_N-1:0] group,
                                     input logic [1:0] idx);
    return group[idx];
  endfunction

endpackage

// File: rtl/wlu_byte_shifter.sv
module wlu_byte_shifter #(
  parameter int unsigned WLEN  = 256,
  parameter int unsigned SHB_W = 5
) (
  input  logic [WLEN-1:0]  din_i,
  input  logic             right_i,
  input  logic [SHB_W-1:0] bytes_i,
  output logic [WLEN-1:0]  dout_o
);
  localparam int unsigned STAGES = SHB_W;

  logic [WLEN-1:0] stg [STAGES+1];

  assign stg[0] = din_i;

  // One stage per bit of the count; stage k moves by 8*2^k bits.
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int unsigned SH = 8 * (2 ** k);
    if (SH >= WLEN) begin : g_clear
      assign stg[k+1] = bytes_i[k] ? '0 : stg[k];
    end else begin : g_move
      assign stg[k+1] = !bytes_i[k] ? stg[k] :
                        (right_i ? (stg[k] >> SH) : (stg[k] << SH));
    end
  end

  assign dout_o = stg[STAGES];
endmodule

// File: rtl/wlu_funnel.sv
module wlu_funnel #(
  parameter int unsigned WLEN = 256,
  localparam int unsigned AMT_W = $clog2(WLEN),
  localparam int unsigned DW    = 2 * WLEN
) (
  input  logic [WLEN-1:0]  hi_i,
  input  logic [WLEN-1:0]  lo_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [WLEN-1:0]  dout_o
);
  logic [DW-1:0] stg [AMT_W+1];

  assign stg[0] = {hi_i, lo_i};

  // Logarithmic right shifter over the double-width value.
  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int unsigned SH = 2 ** k;
    assign stg[k+1] = amt_i[k] ? (stg[k] >> SH) : stg[k];
  end

  assign dout_o = stg[AMT_W][WLEN-1:0];
endmodule

// File: rtl/wlu_bool_unit.sv
module wlu_bool_unit
  import wlu_pkg::*;
#(
  parameter int unsigned WLEN = 256
) (
  input  wlu_op_e         op_i,
  input  logic [WLEN-1:0] a_i,
  input  logic [WLEN-1:0] b_i,
  output logic [WLEN-1:0] dout_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  dout_o = a_i & b_i;
      OP_OR:   dout_o = a_i | b_i;
      OP_XOR:  dout_o = a_i ^ b_i;
      OP_NOT:  dout_o = ~b_i;
      default: dout_o = '0;
    endcase
  end
endmodule

// File: rtl/wlu_flag_select.sv
module wlu_flag_select
  import wlu_pkg::*;
#(
  parameter int unsigned WLEN = 256
) (
  input  logic [WLEN-1:0]   a_i,
  input  logic [WLEN-1:0]   b_i,
  input  logic [FLAG_N-1:0] flags_i,
  input  logic [1:0]        sel_i,
  output logic              hit_o,
  output logic [WLEN-1:0]   dout_o
);
  assign hit_o  = pick_flag(flags_i, sel_i);
  assign dout_o = hit_o ? a_i : b_i;
endmodule

// File: rtl/wide_logic_unit.sv
module wide_logic_unit
  import wlu_pkg::*;
#(
  parameter int unsigned WLEN  = 256,
  parameter int unsigned SHB_W = 5,
  localparam int unsigned FSH_W = $clog2(WLEN)
) (
  input  logic [WLEN-1:0]   opa_i,
  input  logic [WLEN-1:0]   opb_i,
  input  logic [2:0]        op_i,
  input  logic              shift_right_i,
  input  logic [SHB_W-1:0]  shift_bytes_i,
  input  logic [FSH_W-1:0]  funnel_amt_i,
  input  logic [3:0]        flags_i,
  input  logic [1:0]        flag_sel_i,
  output logic [WLEN-1:0]   result_o
);
  wlu_op_e         op;
  logic [WLEN-1:0] b_shifted;
  logic [WLEN-1:0] bool_res;
  logic [WLEN-1:0] funnel_res;
  logic [WLEN-1:0] sel_res;
  logic            flag_hit;

  assign op = wlu_op_e'(op_i);

  wlu_byte_shifter #(.WLEN(WLEN), .SHB_W(SHB_W)) u_bsh (
    .din_i  (opb_i),
    .right_i(shift_right_i),
    .bytes_i(shift_bytes_i),
    .dout_o (b_shifted)
  );

  wlu_bool_unit #(.WLEN(WLEN)) u_bool (
    .op_i  (op),
    .a_i   (opa_i),
    .b_i   (b_shifted),
    .dout_o(bool_res)
  );

  wlu_funnel #(.WLEN(WLEN)) u_fun (
    .hi_i  (opa_i),
    .lo_i  (opb_i),
    .amt_i (funnel_amt_i),
    .dout_o(funnel_res)
  );

  wlu_flag_select #(.WLEN(WLEN)) u_sel (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .flags_i(flags_i),
    .sel_i  (flag_sel_i),
    .hit_o  (flag_hit),
    .dout_o (sel_res)
  );

  always_comb begin
    unique case (op)
      OP_AND, OP_OR, OP_XOR, OP_NOT: result_o = bool_res;
      OP_FUNNEL:                     result_o = funnel_res;
      OP_SELECT:                     result_o = sel_res;
      default:                       result_o = '0;
    endcase
  end
endmodule

// File: rtl/wide_logic_unit_chk.sv
module wide_logic_unit_chk #(
  parameter int unsigned WLEN  = 256,
  parameter int unsigned SHB_W = 5,
  localparam int unsigned FSH_W = $clog2(WLEN)
) (
  input logic [WLEN-1:0]  opa_i,
  input logic [WLEN-1:0]  opb_i,
  input logic [2:0]       op_i,
  input logic             shift_right_i,
  input logic [SHB_W-1:0] shift_bytes_i,
  input logic [FSH_W-1:0] funnel_amt_i,
  input logic [3:0]       flags_i,
  input logic [1:0]       flag_sel_i,
  input logic [WLEN-1:0]  result_o,
  input logic [WLEN-1:0]  b_shifted,
  input logic             flag_hit
);
  always_comb begin
    if (op_i == 3'd3) begin
      p_not_inv_r4: assert (result_o == ~b_shifted)
        else $error("R4 NOT result mismatch");
    end
    if (op_i == 3'd5 && flag_hit) begin
      p_sel_a_r6: assert (result_o == opa_i)
        else $error("R6 select did not return first operand");
    end
    if (op_i == 3'd5 && !flag_hit) begin
      p_sel_b_r6: assert (result_o == opb_i)
        else $error("R6 select did not return second operand");
    end
    if (op_i == 3'd4 && funnel_amt_i == '0) begin
      p_funnel_zero_r5: assert (result_o == opb_i)
        else $error("R5 zero funnel shift changed operand");
    end
    if (shift_bytes_i == '0) begin
      p_noshift_r8: assert (b_shifted == opb_i)
        else $error("R8 zero byte count changed operand");
    end
    if (!shift_right_i && shift_bytes_i != '0) begin
      p_left_fill_r2: assert (b_shifted[7:0] == 8'd0)
        else $error("R2 low byte not cleared");
    end
    if (shift_right_i && shift_bytes_i != '0) begin
      p_right_fill_r3: assert (b_shifted[WLEN-1 -: 8] == 8'd0)
        else $error("R3 high byte not cleared");
    end
    if (op_i[2:1] == 2'b11) begin
      p_rsvd_zero_r7: assert (result_o == '0)
        else $error("R7 reserved op result not zero");
    end
  end
endmodule

bind wide_logic_unit wide_logic_unit_chk #(.WLEN(WLEN), .SHB_W(SHB_W)) u_chk (
  .opa_i        (opa_i),
  .opb_i        (opb_i),
  .op_i         (op_i),
  .shift_right_i(shift_right_i),
  .shift_bytes_i(shift_bytes_i),
  .funnel_amt_i (funnel_amt_i),
  .flags_i      (flags_i),
  .flag_sel_i   (flag_sel_i),
  .result_o     (result_o),
  .b_shifted    (b_shifted),
  .flag_hit     (flag_hit)
);

// File: tb/sim_wide_logic_unit.sv
module sim_wide_logic_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W0 = 256;
  localparam int W1 = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W0-1:0] a0, b0, r0;
  logic [W1-1:0] r1;
  logic [2:0]    op;
  logic          dir;
  logic [4:0]    nb;
  logic [7:0]    amt;
  logic [3:0]    flg;
  logic [1:0]    fsel;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  wide_logic_unit #(.WLEN(W0)) u0 (
    .opa_i(a0), .opb_i(b0), .op_i(op), .shift_right_i(dir),
    .shift_bytes_i(nb), .funnel_amt_i(amt), .flags_i(flg),
    .flag_sel_i(fsel), .result_o(r0)
  );

  wide_logic_unit #(.WLEN(W1)) u1 (
    .opa_i(a0[W1-1:0]), .opb_i(b0[W1-1:0]), .op_i(op), .shift_right_i(dir),
    .shift_bytes_i(nb), .funnel_amt_i(amt[5:0]), .flags_i(flg),
    .flag_sel_i(fsel), .result_o(r1)
  );

  // Reference model, byte by byte and bit by bit, for width w.
  function automatic logic [255:0] model(int w, logic [2:0] o, logic [255:0] a,
                                         logic [255:0] b, bit r, int n, int s,
                                         logic [3:0] f, int fs);
    logic [255:0] bs, res;
    int nbytes;
    nbytes = w / 8;
    bs = '0;
    for (int i = 0; i < nbytes; i++) begin
      int src;
      src = r ? i + n : i - n;
      if (src >= 0 && src < nbytes) bs[8*i +: 8] = b[8*src +: 8];
    end
    res = '0;
    case (o)
      3'd0: res = a & bs;
      3'd1: res = a | bs;
      3'd2: res = a ^ bs;
      3'd3: res = ~bs;
      3'd4: for (int i = 0; i < w; i++) begin
              int j;
              j = i + s;
              res[i] = (j < w) ? b[j] : a[j-w];
            end
      3'd5: res = f[fs] ? a : b;
      default: res = '0;
    endcase
    for (int i = w; i < 256; i++) res[i] = 1'b0;
    return res;
  endfunction

  function automatic logic [255:0] rnd_wide();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic apply(string tag, logic [2:0] o, logic [255:0] a, logic [255:0] b,
                       bit r, logic [4:0] n, logic [7:0] s, logic [3:0] f, logic [1:0] fs);
    logic [255:0] e0, e1;
    @(negedge clk);
    op = o; a0 = a; b0 = b; dir = r; nb = n; amt = s; flg = f; fsel = fs;
    #1;
    e0 = model(W0, o, a, b, r, int'(n), int'(s), f, int'(fs));
    e1 = model(W1, o, {192'd0, a[63:0]}, {192'd0, b[63:0]}, r, int'(n),
               int'(s[5:0]), f, int'(fs));
    total++;
    if (r0 !== e0) begin
      bad++;
      $display("FAIL %s w=256 op=%0d got=%h exp=%h", tag, o, r0, e0);
    end
    total++;
    if (r1 !== e1[W1-1:0]) begin
      bad++;
      $display("FAIL %s w=64 op=%0d got=%h exp=%h", tag, o, r1, e1[W1-1:0]);
    end
  endtask

  function automatic string tag_of(logic [2:0] o);
    case (o)
      3'd0, 3'd1, 3'd2: return "R1";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    logic [255:0] ta, tb;
    void'($urandom(32'd20240611));
    op = '0; a0 = '0; b0 = '0; dir = 1'b0; nb = '0; amt = '0; flg = '0; fsel = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state: all-zero inputs give zero (R1 AND of zeros).
    apply("R1", 3'd0, '0, '0, 1'b0, 5'd0, 8'd0, 4'd0, 2'd0);
    ta = rnd_wide(); tb = rnd_wide();
    apply("R1", 3'd0, ta, tb, 1'b0, 5'd0, 8'd0, 4'd0, 2'd0);
    apply("R1", 3'd1, ta, tb, 1'b1, 5'd3, 8'd0, 4'd0, 2'd0);
    apply("R1", 3'd2, ta, tb, 1'b0, 5'd7, 8'd0, 4'd0, 2'd0);
    // Byte shift directions and extremes.
    apply("R2", 3'd1, '0, tb, 1'b0, 5'd1, 8'd0, 4'd0, 2'd0);
    apply("R3", 3'd1, '0, tb, 1'b1, 5'd1, 8'd0, 4'd0, 2'd0);
    apply("R8", 3'd1, '0, tb, 1'b0, 5'd0, 8'd0, 4'd0, 2'd0);
    apply("R8", 3'd1, '0, {256{1'b1}}, 1'b0, 5'd31, 8'd0, 4'd0, 2'd0);
    apply("R8", 3'd1, '0, {256{1'b1}}, 1'b1, 5'd31, 8'd0, 4'd0, 2'd0);
    apply("R8", 3'd1, '0, tb, 1'b0, 5'd8, 8'd0, 4'd0, 2'd0);
    // NOT ignores the first operand.
    apply("R4", 3'd3, '0, tb, 1'b1, 5'd2, 8'd0, 4'd0, 2'd0);
    apply("R4", 3'd3, {256{1'b1}}, tb, 1'b1, 5'd2, 8'd0, 4'd0, 2'd0);
    // Funnel ends, byte-shift inputs set but without effect.
    apply("R5", 3'd4, ta, tb, 1'b1, 5'd5, 8'd0, 4'd0, 2'd0);
    apply("R5", 3'd4, ta, tb, 1'b0, 5'd9, 8'd1, 4'd0, 2'd0);
    apply("R5", 3'd4, ta, tb, 1'b0, 5'd31, 8'd255, 4'd0, 2'd0);
    apply("R5", 3'd4, ta, tb, 1'b0, 5'd0, 8'd63, 4'd0, 2'd0);
    // Select on each flag position, set and clear.
    for (int k = 0; k < 4; k++) begin
      apply("R6", 3'd5, ta, tb, 1'b0, 5'd4, 8'd0, 4'(1 << k), 2'(k));
      apply("R6", 3'd5, ta, tb, 1'b0, 5'd4, 8'd0, ~4'(1 << k), 2'(k));
    end
    // Reserved codes.
    apply("R7", 3'd6, ta, tb, 1'b0, 5'd0, 8'd3, 4'hF, 2'd0);
    apply("R7", 3'd7, ta, tb, 1'b1, 5'd1, 8'd3, 4'hF, 2'd1);
    // Random mix.
    for (int it = 0; it < 400; it++) begin
      logic [2:0] ro;
      ro = 3'($urandom_range(0, 7));
      apply(tag_of(ro), ro, rnd_wide(), rnd_wide(), 1'($urandom), 5'($urandom),
            8'($urandom), 4'($urandom), 2'($urandom));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule